// File: doc/BRIEF.md
# ATM Header Error Control Generator and Checker

This block sits on a byte-serial ATM cell path and handles the header error control (HEC) byte in both directions. A start-of-cell strobe marks the first byte of each cell. From it the block counts byte positions 1 to 53, so it can find the fifth byte, which holds the HEC, and the last payload byte. Bytes are counted only in cycles where the valid input is high.

On the transmit side, the outgoing stream is the incoming stream delayed by one register stage. By default the fifth byte is overwritten with a CRC-8 computed over the four header bytes before it. Two test controls can corrupt traffic on purpose. One inverts bit 0 of the outgoing HEC byte. The other inverts bit 0 of the final payload byte. All transmit controls are sampled on the start-of-cell byte, so each cell is handled with one consistent setting.

On the receive side, the block recomputes the CRC over the four received header bytes and compares it with the fifth byte. It raises a one-cycle error pulse on a mismatch and counts such pulses in a saturating counter. Receive checking can be switched off.

Top module: `hec_cell_engine`

## Requirements
- R1: After reset, `txOutValid`, `txOutSoc` and `rxHecErr` are low and `rxErrCount` is zero.
- R2: `txOutValid`, `txOutSoc` and `txOutData` follow `txValid`, `txValid && txSoc` and `txData` one clock later. Every byte other than cell positions 5 and 53 passes through unchanged.
- R3: When `txReplaceOff` is low at the start-of-cell byte, output byte 5 is the HEC of bytes 1 to 4. The HEC is CRC-8 with generator x^8+x^2+x+1, initial value 0x00, bits processed most significant bit first, and the remainder XORed with 0x55. For example, header 00 00 00 00 gives 0x55 and header 00 00 00 01 gives 0x52.
- R4: When `txReplaceOff` is high at the start-of-cell byte, input byte 5 passes through unchanged.
- R5: When `txHecErrInj` is high at the start-of-cell byte, bit 0 of output byte 5 is inverted. This applies whether byte 5 was replaced or passed through.
- R6: When `txPayErrInj` is high at the start-of-cell byte, bit 0 of output byte 53 is inverted.
- R7: Transmit control inputs are sampled only on the start-of-cell byte. A change later in the same cell has no effect until the next cell.
- R8: Byte position advances only on valid cycles. A valid byte with `txSoc`/`rxSoc` high is position 1. Valid bytes that arrive after position 53 without a new start strobe are not cell bytes: they are neither modified nor checked.
- R9: When `rxCheckOff` is low and received byte 5 differs from the HEC of received bytes 1 to 4, `rxHecErr` is high for exactly the one cycle after byte 5 is accepted.
- R10: When `rxCheckOff` is high at byte 5, no pulse is raised and `rxErrCount` does not change.
- R11: `rxErrCount` increases by one in the cycle after each `rxHecErr` pulse and holds at its all-ones maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txValid | input | 1 | Transmit byte valid |
| txSoc | input | 1 | Transmit start-of-cell strobe |
| txData | input | 8 | Transmit byte in |
| txReplaceOff | input | 1 | Disable HEC replacement on transmit |
| txHecErrInj | input | 1 | Invert bit 0 of transmitted HEC byte |
| txPayErrInj | input | 1 | Invert bit 0 of last payload byte |
| txOutValid | output | 1 | Transmit byte valid out |
| txOutSoc | output | 1 | Transmit start-of-cell out |
| txOutData | output | 8 | Transmit byte out |
| rxValid | input | 1 | Receive byte valid |
| rxSoc | input | 1 | Receive start-of-cell strobe |
| rxData | input | 8 | Receive byte in |
| rxCheckOff | input | 1 | Disable receive HEC checking |
| rxHecErr | output | 1 | One-cycle receive HEC mismatch pulse |
| rxErrCount | output | ERR_CNT_W | Saturating receive HEC error count |

## Verification
The bench keeps the default 53-byte cell and 4-byte header, so positions 5 and 53 are exercised at their real locations. It narrows `ERR_CNT_W` to 4. A run of cells cut short after their HEC byte can then reach the saturation point at 15 within a few hundred cycles and show that the count holds there. Each cell is sent to both sides at once, so one stimulus covers transmit replacement and receive comparison.

// File: rtl/hec_pkg.sv
package hec_pkg;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef struct packed {
    logic txCrcFirst;
    logic txCrcAcc;
    logic txHecSlot;
    logic txLastSlot;
    logic txRepl;
    logic txHecFlip;
    logic txPayFlip;
    logic rxCrcFirst;
    logic rxCrcAcc;
    logic rxHecSlot;
    logic rxChkEn;
  } hec_strb_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] c;
    logic fb;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ dataIn[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/hec_pos_cnt.sv
module hec_pos_cnt #(
  parameter int CELL_BYTES = 53,
  localparam int POS_W = $clog2(CELL_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             byteSoc,
  output logic [POS_W-1:0] posNow
);

  localparam logic [POS_W-1:0] LAST = POS_W'(CELL_BYTES);

  logic [POS_W-1:0] posQ;

  always_comb begin
    if (byteSoc)                         posNow = POS_W'(1);
    else if (posQ != '0 && posQ < LAST)  posNow = posQ + POS_W'(1);
    else                                 posNow = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          posQ <= '0;
    else if (byteValid) posQ <= (posNow == LAST) ? '0 : posNow;
  end

endmodule

// File: rtl/hec_ctrl.sv
module hec_ctrl
  import hec_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  input  logic      txSoc,
  input  logic      txReplaceOff,
  input  logic      txHecErrInj,
  input  logic      txPayErrInj,
  input  logic      rxValid,
  input  logic      rxSoc,
  input  logic      rxCheckOff,
  output hec_strb_t strb
);

  localparam int POS_W = $clog2(CELL_BYTES + 1);
  localparam logic [POS_W-1:0] HEC_POS  = POS_W'(HDR_BYTES + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES);
  localparam logic [POS_W-1:0] HDR_POS  = POS_W'(HDR_BYTES);

  logic [POS_W-1:0] txPos, rxPos;
  logic replOffQ, hecInjQ, payInjQ;
  logic replOffEff, hecInjEff, payInjEff;
  logic txStart;

  hec_pos_cnt #(.CELL_BYTES(CELL_BYTES)) txCnt_i (
    .clk(clk), .rstN(rstN), .byteValid(txValid), .byteSoc(txSoc), .posNow(txPos));

  hec_pos_cnt #(.CELL_BYTES(CELL_BYTES)) rxCnt_i (
    .clk(clk), .rstN(rstN), .byteValid(rxValid), .byteSoc(rxSoc), .posNow(rxPos));

  assign txStart = txValid && txSoc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replOffQ <= 1'b0;
      hecInjQ  <= 1'b0;
      payInjQ  <= 1'b0;
    end else if (txStart) begin
      replOffQ <= txReplaceOff;
      hecInjQ  <= txHecErrInj;
      payInjQ  <= txPayErrInj;
    end
  end

  assign replOffEff = txStart ? txReplaceOff : replOffQ;
  assign hecInjEff  = txStart ? txHecErrInj  : hecInjQ;
  assign payInjEff  = txStart ? txPayErrInj  : payInjQ;

  always_comb begin
    strb.txCrcFirst = txValid && (txPos == POS_W'(1));
    strb.txCrcAcc   = txValid && (txPos > POS_W'(1)) && (txPos <= HDR_POS);
    strb.txHecSlot  = txValid && (txPos == HEC_POS);
    strb.txLastSlot = txValid && (txPos == LAST_POS);
    strb.txRepl     = !replOffEff;
    strb.txHecFlip  = hecInjEff;
    strb.txPayFlip  = payInjEff;
    strb.rxCrcFirst = rxValid && (rxPos == POS_W'(1));
    strb.rxCrcAcc   = rxValid && (rxPos > POS_W'(1)) && (rxPos <= HDR_POS);
    strb.rxHecSlot  = rxValid && (rxPos == HEC_POS);
    strb.rxChkEn    = !rxCheckOff;
  end

endmodule

// File: rtl/hec_dpath.sv
module hec_dpath
  import hec_pkg::*;
#(
  parameter int ERR_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hec_strb_t            strb,
  input  logic                 txValid,
  input  logic                 txSoc,
  input  logic [7:0]           txData,
  output logic                 txOutValid,
  output logic                 txOutSoc,
  output logic [7:0]           txOutData,
  input  logic [7:0]           rxData,
  output logic                 rxHecErr,
  output logic [ERR_CNT_W-1:0] rxErrCount
);

  localparam logic [ERR_CNT_W-1:0] CNT_MAX = '1;

  logic [7:0] txCrcQ, rxCrcQ;
  logic [7:0] txBase;
  logic       txFlip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCrcQ <= '0;
      rxCrcQ <= '0;
    end else begin
      if (strb.txCrcFirst)    txCrcQ <= crc8Step(8'h00, txData);
      else if (strb.txCrcAcc) txCrcQ <= crc8Step(txCrcQ, txData);
      if (strb.rxCrcFirst)    rxCrcQ <= crc8Step(8'h00, rxData);
      else if (strb.rxCrcAcc) rxCrcQ <= crc8Step(rxCrcQ, rxData);
    end
  end

  assign txBase = (strb.txHecSlot && strb.txRepl) ? (txCrcQ ^ HEC_COSET) : txData;
  assign txFlip = (strb.txHecSlot && strb.txHecFlip) || (strb.txLastSlot && strb.txPayFlip);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOutValid <= 1'b0;
      txOutSoc   <= 1'b0;
      txOutData  <= '0;
    end else begin
      txOutValid <= txValid;
      txOutSoc   <= txValid && txSoc;
      txOutData  <= txBase ^ {7'b0, txFlip};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHecErr   <= 1'b0;
      rxErrCount <= '0;
    end else begin
      rxHecErr <= strb.rxHecSlot && strb.rxChkEn && (rxData != (rxCrcQ ^ HEC_COSET));
      if (rxHecErr && rxErrCount != CNT_MAX) rxErrCount <= rxErrCount + 1'b1;
    end
  end

endmodule

// File: rtl/hec_cell_engine.sv
module hec_cell_engine
  import hec_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  parameter int ERR_CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 txValid,
  input  logic                 txSoc,
  input  logic [7:0]           txData,
  input  logic                 txReplaceOff,
  input  logic                 txHecErrInj,
  input  logic                 txPayErrInj,
  output logic                 txOutValid,
  output logic                 txOutSoc,
  output logic [7:0]           txOutData,
  input  logic                 rxValid,
  input  logic                 rxSoc,
  input  logic [7:0]           rxData,
  input  logic                 rxCheckOff,
  output logic                 rxHecErr,
  output logic [ERR_CNT_W-1:0] rxErrCount
);

  hec_strb_t strb;

  hec_ctrl #(.CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txValid(txValid), .txSoc(txSoc),
    .txReplaceOff(txReplaceOff), .txHecErrInj(txHecErrInj), .txPayErrInj(txPayErrInj),
    .rxValid(rxValid), .rxSoc(rxSoc), .rxCheckOff(rxCheckOff),
    .strb(strb));

  hec_dpath #(.ERR_CNT_W(ERR_CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txValid(txValid), .txSoc(txSoc), .txData(txData),
    .txOutValid(txOutValid), .txOutSoc(txOutSoc), .txOutData(txOutData),
    .rxData(rxData), .rxHecErr(rxHecErr), .rxErrCount(rxErrCount));

endmodule

// File: rtl/hec_cell_engine_chk.sv
module hec_cell_engine_chk #(
  parameter int ERR_CNT_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 txValid,
  input logic                 txSoc,
  input logic                 txOutValid,
  input logic                 txOutSoc,
  input logic                 rxCheckOff,
  input logic                 rxHecErr,
  input logic [ERR_CNT_W-1:0] rxErrCount
);

  localparam logic [ERR_CNT_W-1:0] CNT_MAX = '1;

  // R2
  tx_valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> txOutValid);

  // R2
  tx_soc_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txSoc) |=> txOutSoc);

  // R9
  rx_err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxHecErr |=> !rxHecErr);

  // R10
  rx_err_needs_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxHecErr |-> $past(!rxCheckOff));

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxHecErr && rxErrCount != CNT_MAX) |=> rxErrCount == $past(rxErrCount) + 1'b1);

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxHecErr |=> $stable(rxErrCount));

endmodule

bind hec_cell_engine hec_cell_engine_chk #(.ERR_CNT_W(ERR_CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txSoc(txSoc),
  .txOutValid(txOutValid), .txOutSoc(txOutSoc), .rxCheckOff(rxCheckOff),
  .rxHecErr(rxHecErr), .rxErrCount(rxErrCount));

// File: tb/hec_cell_engine_tb_top.sv
module hec_cell_engine_tb_top;

  localparam int CLK_PER = 10;
  localparam int CNT_W   = 4;
  localparam int CELL    = 53;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txValid = 0, txSoc = 0, txReplaceOff = 0, txHecErrInj = 0, txPayErrInj = 0;
  logic rxValid = 0, rxSoc = 0, rxCheckOff = 0;
  logic [7:0] txData = '0, rxData = '0;
  logic txOutValid, txOutSoc, rxHecErr;
  logic [7:0] txOutData;
  logic [CNT_W-1:0] rxErrCount;

  int checks = 0;
  int fails = 0;
  int expCnt = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  hec_cell_engine #(.ERR_CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .txValid(txValid), .txSoc(txSoc), .txData(txData),
    .txReplaceOff(txReplaceOff), .txHecErrInj(txHecErrInj), .txPayErrInj(txPayErrInj),
    .txOutValid(txOutValid), .txOutSoc(txOutSoc), .txOutData(txOutData),
    .rxValid(rxValid), .rxSoc(rxSoc), .rxData(rxData), .rxCheckOff(rxCheckOff),
    .rxHecErr(rxHecErr), .rxErrCount(rxErrCount));

  // {hdr[31:0], byte5[7:0], repOff, chkOff, hInj, pInj, flipMid, gap}
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {32'h00000000, 8'h55, 6'b000000},
    {32'h00000001, 8'h52, 6'b000000},
    {32'h12345678, 8'h00, 6'b000000},
    {32'h12345678, 8'h00, 6'b100000},
    {32'hAABBCCDD, 8'h11, 6'b001000},
    {32'h0F0F0F0F, 8'h00, 6'b010101},
    {32'h00000001, 8'h52, 6'b101010},
    {32'hDEADBEEF, 8'hFF, 6'b001101}
  };

  // reference HEC: remainder of (header * x^8) modulo 0x107, then coset
  function automatic logic [7:0] refHec(input logic [31:0] hdr);
    logic [39:0] r;
    r = {hdr, 8'h00};
    for (int b = 39; b >= 8; b--)
      if (r[b]) r[b -: 9] = r[b -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    txValid = 0; txSoc = 0; rxValid = 0; rxSoc = 0;
    @(posedge clk); #1;
  endtask

  task automatic sendCell(input logic [31:0] hdr, input logic [7:0] b5,
                          input bit repOff, input bit chkOff, input bit hInj,
                          input bit pInj, input bit flipMid, input bit gap,
                          input int nBytes);
    logic [7:0] hec, d, e;
    hec = refHec(hdr);
    for (int i = 1; i <= nBytes; i++) begin
      if (gap && i == 3) begin
        idle();
        check(txOutValid, 0, "R8 gap no valid");
      end
      @(negedge clk);
      if (i == 1) begin
        txReplaceOff = repOff; txHecErrInj = hInj; txPayErrInj = pInj; rxCheckOff = chkOff;
      end else if (i == 2 && flipMid) begin
        txReplaceOff = !repOff; txHecErrInj = !hInj; txPayErrInj = !pInj;
      end
      if (i <= 4)      d = hdr[39 - 8*i -: 8];
      else if (i == 5) d = b5;
      else             d = 8'(i * 7) ^ hdr[7:0];
      txValid = 1; txSoc = (i == 1); txData = d;
      rxValid = 1; rxSoc = (i == 1); rxData = d;
      @(posedge clk); #1;
      e = d;
      if (i == 5) e = (repOff ? b5 : hec) ^ {7'b0, hInj};
      if (i == CELL) e = d ^ {7'b0, pInj};
      check(txOutValid, 1, "R2 valid");
      check(txOutSoc, (i == 1), "R2 soc");
      if (i == 5)         check(txOutData, e, "R3 R4 R5 R7 hec byte");
      else if (i == CELL) check(txOutData, e, "R6 R7 last byte");
      else                check(txOutData, e, "R2 passthrough");
      if (i == 5) begin
        check(rxHecErr, (!chkOff && b5 != hec), "R9 R10 rx pulse");
        if (!chkOff && b5 != hec && expCnt < (1 << CNT_W) - 1) expCnt++;
      end
      if (i == 6) check(rxHecErr, 0, "R9 pulse width");
    end
    idle();
    check(rxErrCount, expCnt, "R10 R11 count");
  endtask

  initial begin
    repeat (CLK_PER * 20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [45:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(txOutValid, 0, "R1 txOutValid");
    check(txOutSoc, 0, "R1 txOutSoc");
    check(rxHecErr, 0, "R1 rxHecErr");
    check(rxErrCount, 0, "R1 rxErrCount");
    @(negedge clk); rstN = 1;
    idle();

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      sendCell(v[45:14], v[13:6], v[5], v[4], v[3], v[2], v[1], v[0], CELL);
    end

    // R7: controls raised mid-cell act only on the next cell
    sendCell(32'h11223344, 8'h00, 0, 0, 0, 0, 1, 0, CELL);
    sendCell(32'h11223344, 8'h00, 1, 0, 1, 1, 0, 0, CELL);

    // R8: stray valid bytes after a cell, no soc: untouched, unchecked
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      txHecErrInj = 1; txPayErrInj = 1; rxCheckOff = 0;
      txValid = 1; txSoc = 0; txData = 8'hA0 + 8'(i);
      rxValid = 1; rxSoc = 0; rxData = 8'hA0 + 8'(i);
      @(posedge clk); #1;
      check(txOutData, 8'hA0 + 8'(i), "R8 stray tx byte");
      check(txOutSoc, 0, "R8 stray soc");
      check(rxHecErr, 0, "R8 stray rx unchecked");
    end
    idle();
    check(rxErrCount, expCnt, "R8 count unchanged");

    // R11: saturation using short cells with bad HEC
    for (int n = 0; n < 20; n++)
      sendCell(32'h01020304, 8'h00, 0, 0, 0, 0, 0, 0, 5);
    check(rxErrCount, (1 << CNT_W) - 1, "R11 saturated");

    // R10: check disabled, bad HEC, count frozen
    sendCell(32'h01020304, 8'h00, 0, 1, 0, 0, 0, 0, 6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule